// File: doc/BRIEF.md
# Pulse Phase Width Meter

This block measures how long a single digital input stays high and how long it stays low. Two counters share one input. One counts only while the synchronized input is high and the other only while it is low, so between edges each holds the width of the phase just measured. Both counters advance on a common divide-by-four tick. A width therefore reads in units of four system clocks.

When a phase ends, the edge that ends it raises a sticky request flag belonging to the counter that measured that phase. Software either polls these flags in a pending register or reacts to them, then reads the counter and reloads it for the next pulse. A counter that passes its all-ones value wraps to zero and latches a sticky wrap flag. That flag may raise an interrupt, so software can tell that a phase was longer than the counter range.

Software reaches the block through a small register port. It is write-strobed with a 2-bit address and has a combinational read path.

Top module: `pulse_phase_meter`

## Requirements
- R1: After reset the configuration, both counts and all pending bits read zero, and `irq` is low. The counter width is the parameter `CNT_W`, which defaults to 16.
- R2: Address 0 holds the configuration: bit 0 enables measuring, bit 1 enables the wrap interrupt of the high counter, and bit 2 enables the wrap interrupt of the low counter. The value reads back. While bit 0 is clear, input activity changes neither count nor any pending bit.
- R3: The high counter, read at address 1, advances by one on each tick on which the synchronized input is high. Ticks fall on the 4th, 8th, 12th and later clock edges after the edge that wrote bit 0 to one.
- R4: The low counter, read at address 2, advances on the same ticks when the synchronized input is low.
- R5: A level that `pulseIn` presents at clock edge n first steers counting at edge n+2. A request flag caused by a change at edge n appears at edge n+2.
- R6: Address 3 is the pending register. Bit 0 is set by a falling edge, which ends a high phase and so belongs to the high counter. Bit 1 is set by a rising edge, which ends a low phase and so belongs to the low counter. Edges set these bits only while measuring is enabled.
- R7: Writing a one to a pending bit clears it. An edge or wrap that sets the same bit in the same cycle wins over the clear.
- R8: A write to a count address loads the written value (zero to clear it), and this load wins over a tick in the same cycle.
- R9: When a counter ticks at all-ones it wraps to zero and sets its wrap flag: pending bit 2 for the high counter and bit 3 for the low counter. The flag stays set until it is written with one.
- R10: `irq` is high exactly when some wrap flag is set while its interrupt-enable bit is set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| pulseIn | input | 1 | Asynchronous pulse train being measured |
| regAddr | input | 2 | Register address for reads and writes |
| regWrEn | input | 1 | Write strobe, taken at the clock edge |
| regWrData | input | CNT_W | Write data |
| regRdData | output | CNT_W | Read data for `regAddr`, combinational |
| irq | output | 1 | Wrap interrupt request |

## Verification
Each result has a fixed due cycle. A count includes a tick at edge j only if the input sampled at edge j-2 had the right level and j lies a multiple of four edges after the enabling write. An edge flag is due at the second edge after the edge that first samples the new level. A register write acts at its own edge. The bench records the input level it drove at every clock edge and works out each expected count and flag from that record and the edge numbers of its own writes. It reads the combinational register port and `irq` at the falling edge, so every value it compares has settled from the edge before.

// File: rtl/ppm_pkg.sv
package ppm_pkg;

  // register addresses
  localparam logic [1:0] ADDR_CFG  = 2'd0;
  localparam logic [1:0] ADDR_CNT0 = 2'd1;
  localparam logic [1:0] ADDR_CNT1 = 2'd2;
  localparam logic [1:0] ADDR_PEND = 2'd3;

  // configuration bit positions
  localparam int CFG_MODE = 0;
  localparam int CFG_IE0  = 1;
  localparam int CFG_IE1  = 2;
  localparam int CFG_W    = 3;

  // pending register: [1:0] phase-end requests, [3:2] wrap flags
  localparam int PEND_W   = 4;
  localparam int CHANNELS = 2;

  // strobes from control to datapath; index 0 = high-phase counter
  typedef struct packed {
    logic [CHANNELS-1:0] inc;
    logic [CHANNELS-1:0] load;
    logic [CHANNELS-1:0] edgeSet;
    logic [PEND_W-1:0]   w1c;
  } ppmStrobeT;

endpackage

// File: rtl/ppm_ctrl.sv
module ppm_ctrl
  import ppm_pkg::*;
#(
  parameter int PRESC_DIV = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              pulseIn,
  input  logic [1:0]        regAddr,
  input  logic              regWrEn,
  input  logic [PEND_W-1:0] wrLow,
  output ppmStrobeT         strb,
  output logic [CFG_W-1:0]  cfgBits,
  output logic              syncLevel,
  output logic              syncPrev
);

  localparam int PW = (PRESC_DIV > 1) ? $clog2(PRESC_DIV) : 1;
  localparam logic [PW-1:0] PRESC_LAST = PW'(PRESC_DIV - 1);

  logic          syncMeta;
  logic [PW-1:0] prescCnt;
  logic          modeEn;
  logic          tick;
  logic          cfgWr;

  assign modeEn = cfgBits[CFG_MODE];
  assign tick   = modeEn && (prescCnt == PRESC_LAST);
  assign cfgWr  = regWrEn && (regAddr == ADDR_CFG);

  // two-flop synchronizer plus one history flop for edge detection
  always_ff @(posedge clk) begin
    if (!rstN) begin
      syncMeta  <= 1'b0;
      syncLevel <= 1'b0;
      syncPrev  <= 1'b0;
    end else begin
      syncMeta  <= pulseIn;
      syncLevel <= syncMeta;
      syncPrev  <= syncLevel;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfgBits <= '0;
    end else if (cfgWr) begin
      cfgBits <= wrLow[CFG_W-1:0];
    end
  end

  // prescaler restarts whenever measuring is off
  always_ff @(posedge clk) begin
    if (!rstN) begin
      prescCnt <= '0;
    end else if (!modeEn || tick) begin
      prescCnt <= '0;
    end else begin
      prescCnt <= prescCnt + 1'b1;
    end
  end

  always_comb begin
    strb         = '0;
    strb.inc[0]  = tick && syncLevel;
    strb.inc[1]  = tick && !syncLevel;
    strb.load[0] = regWrEn && (regAddr == ADDR_CNT0);
    strb.load[1] = regWrEn && (regAddr == ADDR_CNT1);
    // falling edge ends a high phase -> channel 0; rising ends low -> channel 1
    strb.edgeSet[0] = modeEn && !syncLevel && syncPrev;
    strb.edgeSet[1] = modeEn && syncLevel && !syncPrev;
    strb.w1c     = (regWrEn && (regAddr == ADDR_PEND)) ? wrLow : '0;
  end

endmodule

// File: rtl/ppm_datapath.sv
module ppm_datapath
  import ppm_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic                             clk,
  input  logic                             rstN,
  input  ppmStrobeT                        strb,
  input  logic [CFG_W-1:0]                 cfgBits,
  input  logic [1:0]                       regAddr,
  input  logic [CNT_W-1:0]                 regWrData,
  output logic [CNT_W-1:0]                 regRdData,
  output logic                             irq,
  output logic [CHANNELS-1:0][CNT_W-1:0]   cntVal,
  output logic [PEND_W-1:0]                pendFlags
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CHANNELS-1:0] irqVec;

  for (genvar i = 0; i < CHANNELS; i++) begin : g_ch
    logic [CNT_W-1:0] cntQ;
    logic             reqQ;
    logic             maxQ;
    logic             wrap;

    assign wrap = strb.inc[i] && !strb.load[i] && (cntQ == CNT_MAX);

    always_ff @(posedge clk) begin
      if (!rstN) begin
        cntQ <= '0;
      end else if (strb.load[i]) begin
        cntQ <= regWrData;
      end else if (strb.inc[i]) begin
        cntQ <= cntQ + 1'b1;
      end
    end

    always_ff @(posedge clk) begin
      if (!rstN) begin
        reqQ <= 1'b0;
      end else if (strb.edgeSet[i]) begin
        reqQ <= 1'b1;
      end else if (strb.w1c[i]) begin
        reqQ <= 1'b0;
      end
    end

    always_ff @(posedge clk) begin
      if (!rstN) begin
        maxQ <= 1'b0;
      end else if (wrap) begin
        maxQ <= 1'b1;
      end else if (strb.w1c[CHANNELS+i]) begin
        maxQ <= 1'b0;
      end
    end

    assign cntVal[i]             = cntQ;
    assign pendFlags[i]          = reqQ;
    assign pendFlags[CHANNELS+i] = maxQ;
    assign irqVec[i]             = maxQ && cfgBits[CFG_IE0+i];
  end

  assign irq = |irqVec;

  always_comb begin
    unique case (regAddr)
      ADDR_CFG:  regRdData = {{(CNT_W-CFG_W){1'b0}}, cfgBits};
      ADDR_CNT0: regRdData = cntVal[0];
      ADDR_CNT1: regRdData = cntVal[1];
      default:   regRdData = {{(CNT_W-PEND_W){1'b0}}, pendFlags};
    endcase
  end

endmodule

// File: rtl/pulse_phase_meter.sv
module pulse_phase_meter
  import ppm_pkg::*;
#(
  parameter int CNT_W     = 16,
  parameter int PRESC_DIV = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             pulseIn,
  input  logic [1:0]       regAddr,
  input  logic             regWrEn,
  input  logic [CNT_W-1:0] regWrData,
  output logic [CNT_W-1:0] regRdData,
  output logic             irq
);

  ppmStrobeT                      strb;
  logic [CFG_W-1:0]               cfgBits;
  logic                           syncLevel;
  logic                           syncPrev;
  logic                           modeEn;
  logic [CHANNELS-1:0][CNT_W-1:0] cntVal;
  logic [PEND_W-1:0]              pendFlags;

  assign modeEn = cfgBits[CFG_MODE];

  ppm_ctrl #(.PRESC_DIV(PRESC_DIV)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .pulseIn   (pulseIn),
    .regAddr   (regAddr),
    .regWrEn   (regWrEn),
    .wrLow     (regWrData[PEND_W-1:0]),
    .strb      (strb),
    .cfgBits   (cfgBits),
    .syncLevel (syncLevel),
    .syncPrev  (syncPrev)
  );

  ppm_datapath #(.CNT_W(CNT_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .cfgBits   (cfgBits),
    .regAddr   (regAddr),
    .regWrData (regWrData),
    .regRdData (regRdData),
    .irq       (irq),
    .cntVal    (cntVal),
    .pendFlags (pendFlags)
  );

endmodule

// File: rtl/ppm_checker.sv
module ppm_checker
  import ppm_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input logic                           clk,
  input logic                           rstN,
  input logic                           irq,
  input ppmStrobeT                      strb,
  input logic                           modeEn,
  input logic                           syncLevel,
  input logic                           syncPrev,
  input logic [CHANNELS-1:0][CNT_W-1:0] cntVal,
  input logic [PEND_W-1:0]              pendFlags
);

  p_hold_when_off_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!modeEn && !strb.load[0]) |=> $stable(cntVal[0]));

  p_single_phase_r3: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.inc[0] && strb.inc[1]));

  p_tick_gap_r3: assert property (@(posedge clk) disable iff (!rstN)
    (strb.inc != '0) |=> (strb.inc == '0));

  p_rise_flag_r6: assert property (@(posedge clk) disable iff (!rstN)
    (modeEn && syncLevel && !syncPrev) |=> pendFlags[1]);

  p_fall_flag_r6: assert property (@(posedge clk) disable iff (!rstN)
    (modeEn && !syncLevel && syncPrev) |=> pendFlags[0]);

  p_wrap_sticky_r9: assert property (@(posedge clk) disable iff (!rstN)
    (pendFlags[2] && !strb.w1c[2]) |=> pendFlags[2]);

  p_irq_source_r10: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> (pendFlags[3:2] != 2'b00));

endmodule

bind pulse_phase_meter ppm_checker #(.CNT_W(CNT_W)) u_ppmChk (
  .clk       (clk),
  .rstN      (rstN),
  .irq       (irq),
  .strb      (strb),
  .modeEn    (modeEn),
  .syncLevel (syncLevel),
  .syncPrev  (syncPrev),
  .cntVal    (cntVal),
  .pendFlags (pendFlags)
);

// File: tb/tb_pulse_phase_meter.sv
`timescale 1ns/1ps
module tb_pulse_phase_meter;

  localparam int W    = 8;
  localparam int MODV = 1 << W;
  localparam int BIG  = 1 << 30;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         pulseIn = 1'b0;
  logic [1:0]   regAddr = 2'd0;
  logic         regWrEn = 1'b0;
  logic [W-1:0] regWrData = '0;
  logic [W-1:0] regRdData;
  logic         irq;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  logic hist [0:32767];

  int enCyc = BIG;
  int disCyc = BIG;
  logic modeShadow = 1'b0;
  int ld0Cyc = 0, ld1Cyc = 0, ld0Val = 0, ld1Val = 0, pclrCyc = 0;
  int lastWr = 0;

  always #4 clk = ~clk;

  pulse_phase_meter #(.CNT_W(W)) dut (
    .clk(clk), .rstN(rstN), .pulseIn(pulseIn), .regAddr(regAddr),
    .regWrEn(regWrEn), .regWrData(regWrData), .regRdData(regRdData), .irq(irq)
  );

  always @(posedge clk) begin
    if (cyc < 32768) hist[cyc] <= pulseIn;
    cyc <= cyc + 1;
  end

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic bit enabledAt(input int j);
    return (j > enCyc) && (j <= disCyc);
  endfunction

  // ticks in (fromExcl, last edge] where the input sampled two edges earlier equals lvl
  function automatic int countTicks(input logic lvl, input int fromExcl);
    int n = 0;
    for (int j = fromExcl + 1; j <= cyc - 1; j++) begin
      if (j >= 2 && enabledAt(j) && ((j - enCyc) % 4 == 0) && hist[j-2] == lvl) n++;
    end
    return n;
  endfunction

  function automatic int edgeSeen(input logic rise, input int fromIncl);
    for (int j = fromIncl; j <= cyc - 1; j++) begin
      if (j >= 3 && enabledAt(j)) begin
        if (rise && hist[j-2] && !hist[j-3]) return 1;
        if (!rise && !hist[j-2] && hist[j-3]) return 1;
      end
    end
    return 0;
  endfunction

  task automatic regWrite(input logic [1:0] a, input int d);
    @(negedge clk);
    regAddr = a; regWrData = W'(d); regWrEn = 1'b1;
    @(posedge clk);
    lastWr = cyc;
    @(negedge clk);
    regWrEn = 1'b0;
    case (a)
      2'd0: begin
        if (d[0] && !modeShadow) begin enCyc = lastWr; disCyc = BIG; end
        if (!d[0] && modeShadow) disCyc = lastWr;
        modeShadow = d[0];
      end
      2'd1: begin ld0Cyc = lastWr; ld0Val = d; end
      2'd2: begin ld1Cyc = lastWr; ld1Val = d; end
      default: pclrCyc = lastWr;
    endcase
  endtask

  task automatic regRead(input logic [1:0] a, output int v);
    regAddr = a;
    #1;
    v = int'(regRdData);
  endtask

  task automatic settle(input logic lvl);
    pulseIn = lvl;
    repeat (5) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int v, c0, c1, e0, e1, p;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    regRead(2'd0, v); check("R1", "config", v, 0);
    regRead(2'd1, v); check("R1", "count0", v, 0);
    regRead(2'd2, v); check("R1", "count1", v, 0);
    regRead(2'd3, v); check("R1", "pending", v, 0);
    check("R1", "irq", int'(irq), 0);

    // R2 disabled after reset: input activity ignored
    for (int k = 0; k < 6; k++) begin
      pulseIn = ~pulseIn;
      repeat (k + 3) @(negedge clk);
    end
    settle(1'b0);
    regRead(2'd1, v); check("R2", "count0 off", v, 0);
    regRead(2'd2, v); check("R2", "count1 off", v, 0);
    regRead(2'd3, v); check("R2", "pending off", v, 0);

    regWrite(2'd0, 1);
    regRead(2'd0, v); check("R2", "config readback", v, 1);

    // R3 R4 R5 R6 sweep of phase widths
    for (int h = 1; h <= 8; h++) begin
      for (int l = 1; l <= 8; l++) begin
        regWrite(2'd1, 0);
        regWrite(2'd2, 0);
        regWrite(2'd3, 3);
        for (int r = 0; r < 3; r++) begin
          pulseIn = 1'b1; repeat (h) @(negedge clk);
          pulseIn = 1'b0; repeat (l) @(negedge clk);
        end
        repeat (3) @(negedge clk);
        e0 = (ld0Val + countTicks(1'b1, ld0Cyc)) % MODV;
        e1 = (ld1Val + countTicks(1'b0, ld1Cyc)) % MODV;
        regRead(2'd1, v); check("R3", "high count", v, e0);
        regRead(2'd2, v); check("R4", "low count", v, e1);
        regRead(2'd3, v);
        check("R6", "fall request", v & 1, edgeSeen(1'b0, pclrCyc));
        check("R6", "rise request", (v >> 1) & 1, edgeSeen(1'b1, pclrCyc));
      end
    end

    // R8 load wins over tick, every prescaler phase
    settle(1'b1);
    for (int ph = 0; ph < 4; ph++) begin
      repeat (ph) @(negedge clk);
      regWrite(2'd1, 16 + ph);
      regRead(2'd1, v); check("R8", "load value", v, 16 + ph);
      repeat (6) @(negedge clk);
      regRead(2'd1, v); check("R8", "count after load", v, (ld0Val + countTicks(1'b1, ld0Cyc)) % MODV);
    end

    // R5 edge flag latency
    settle(1'b0);
    regWrite(2'd3, 15);
    pulseIn = 1'b1;
    @(negedge clk); regRead(2'd3, v); check("R5", "flag after edge n", (v >> 1) & 1, 0);
    @(negedge clk); regRead(2'd3, v); check("R5", "flag after edge n+1", (v >> 1) & 1, 0);
    @(negedge clk); regRead(2'd3, v); check("R5", "flag after edge n+2", (v >> 1) & 1, 1);

    // R7 set wins over simultaneous clear, plain clear works
    settle(1'b0);
    regWrite(2'd3, 15);
    pulseIn = 1'b1;
    @(negedge clk);
    @(negedge clk);
    regAddr = 2'd3; regWrData = 8'd2; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
    regRead(2'd3, v); check("R7", "set beats clear", (v >> 1) & 1, 1);
    regWrite(2'd3, 2);
    regRead(2'd3, v); check("R7", "write-one clears", (v >> 1) & 1, 0);

    // R2 disabled mid-run
    regWrite(2'd0, 0);
    regWrite(2'd3, 15);
    regRead(2'd1, c0);
    regRead(2'd2, c1);
    for (int k = 0; k < 5; k++) begin
      pulseIn = ~pulseIn;
      repeat (k + 6) @(negedge clk);
    end
    regRead(2'd1, v); check("R2", "count0 frozen", v, c0);
    regRead(2'd2, v); check("R2", "count1 frozen", v, c1);
    regRead(2'd3, v); check("R2", "no request when off", v, 0);

    // R9 R10 high counter wrap
    settle(1'b1);
    regWrite(2'd0, 3);
    regWrite(2'd1, 250);
    while (countTicks(1'b1, ld0Cyc) < 5) @(negedge clk);
    regRead(2'd1, v); check("R9", "count at max", v, 255);
    regRead(2'd3, p); check("R9", "no wrap yet", (p >> 2) & 1, 0);
    check("R10", "irq before wrap", int'(irq), 0);
    while (countTicks(1'b1, ld0Cyc) < 6) @(negedge clk);
    regRead(2'd1, v); check("R9", "wrapped count", v, 0);
    regRead(2'd3, p); check("R9", "wrap flag", (p >> 2) & 1, 1);
    check("R10", "irq on wrap", int'(irq), 1);
    repeat (12) @(negedge clk);
    regRead(2'd3, p); check("R9", "wrap flag sticky", (p >> 2) & 1, 1);
    regWrite(2'd0, 1);
    check("R10", "irq masked", int'(irq), 0);
    regWrite(2'd0, 3);
    check("R10", "irq unmasked", int'(irq), 1);
    regWrite(2'd3, 4);
    regRead(2'd3, p); check("R9", "wrap flag cleared", (p >> 2) & 1, 0);
    check("R10", "irq after clear", int'(irq), 0);

    // R9 R10 low counter wrap
    settle(1'b0);
    regWrite(2'd0, 5);
    regWrite(2'd2, 253);
    while (countTicks(1'b0, ld1Cyc) < 3) @(negedge clk);
    regRead(2'd2, v); check("R9", "low wrapped count", v, 0);
    regRead(2'd3, p); check("R9", "low wrap flag", (p >> 3) & 1, 1);
    check("R10", "irq low wrap", int'(irq), 1);
    regWrite(2'd3, 8);
    check("R10", "irq low cleared", int'(irq), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule